// File: doc/BRIEF.md
# Differential configuration bank controller

This controller sits between a processor and four parallel reconfigurable arrays. Candidate configurations live in a banked store. The processor fills a bank through a 32-bit port and marks it ready. The controller then streams the bank out one column per cycle through a 256-bit internal read path. Each bank keeps only one full configuration. The other three candidates are stored as bit-flip masks, and the controller restores them by XOR while it loads the columns.

Once every column has been written into the arrays, the controller pulses an evaluation start. When the arrays report that fitness is ready, it raises an interrupt naming the bank that was scored. The interrupt holds until the processor acknowledges it. Banks are visited in strict rotation, so the processor can refill one bank while another is being loaded or scored.

Top module: `cbk_top`

## Requirements
- R1: After reset, `col_we`, `eval_start` and `irq` are 0, every bank ready bit is 0, and the first bank visited is bank 0.
- R2: A processor access with address bit 7 = 0 reaches the store. The address is split as {bank (bit 6), column (bits 5:3), lane (bits 2:0)}, and lane L covers word bits [32L+31:32L]. A write stores `cpu_wdata` in that lane. A read returns the lane on `cpu_rdata` one cycle after `cpu_re`.
- R3: A processor write with address bit 7 = 1 sets the ready bit of bank b for every set bit b of `cpu_wdata`. Zero bits leave the ready bits unchanged. A read at that address returns the ready bits in the low bits of the data, with all other bits zero.
- R4: While the bank that is due is not ready, no column is written and no evaluation starts, even if some other bank is ready.
- R5: Loading a ready bank raises `col_we` for 8 consecutive cycles, with `col_idx` going 0, 1, … 7.
- R6: For each column, the word is split into four 64-bit sections, with section s at bits [64s+63:64s]. Array 0 receives the low 48 bits of section 0. Array a (a = 1..3) receives the low 48 bits of section 0 XOR section a. Array a's field on `col_cfg` is bits [48a+47:48a].
- R7: `eval_start` pulses for one cycle, in the cycle after the last column write and with `col_we` low. The loaded bank's ready bit is already cleared by hardware when the pulse appears.
- R8: Banks are visited in rotation 0, 1, 0, … and a bank that is not due is never skipped to.
- R9: A `fit_done` during evaluation raises `irq` in the next cycle, with `irq_bank` set to the evaluated bank. Both hold until `irq_ack`.
- R10: `irq` falls the cycle after `irq_ack`. A result that is ready while `irq` is pending raises `irq` only after the acknowledgement, with one low cycle in between.
- R11: The next ready bank is loaded and evaluated while the previous interrupt is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Processor write strobe |
| cpu_re | input | 1 | Processor read strobe |
| cpu_addr | input | 8 | Processor address: register select, bank, column, lane |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data, one cycle after `cpu_re` |
| col_we | output | 1 | Column load strobe to all arrays |
| col_idx | output | 3 | Column being loaded |
| col_cfg | output | 192 | Four 48-bit column configurations, array 0 in the low bits |
| eval_start | output | 1 | Start-of-evaluation pulse |
| fit_done | input | 1 | Fitness results of the current bank are ready |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_bank | output | 1 | Bank whose results raised `irq` |

## Verification
The assertions assume that `fit_done` arrives only after `eval_start`, at most once per evaluation. They also assume that `irq_ack` is given only while `irq` is high, and that the processor never writes a bank that is ready or being loaded. The stimulus respects all three. It pulses `fit_done` a few cycles after each observed start pulse and acknowledges only a visible interrupt. It refills a bank only once that bank's ready bit reads back as cleared.

// File: rtl/cbk_pkg.sv
package cbk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_START,
    ST_EVAL,
    ST_HOLD
  } seq_state_t;

  // index width for n items, at least one bit
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // rebuild one 48/COL_W configuration from base slice and flip mask
  function automatic logic [63:0] apply_mask(input logic [63:0] base,
                                             input logic [63:0] mask,
                                             input logic use_mask);
    return use_mask ? (base ^ mask) : base;
  endfunction

endpackage

// File: rtl/cbk_store.sv
module cbk_store import cbk_pkg::*; #(
  parameter int NUM_BANKS = 2,
  parameter int NUM_COLS  = 8,
  parameter int WORD_W    = 256,
  parameter int CPU_W     = 32,
  parameter int BB        = idx_bits(NUM_BANKS),
  parameter int CB        = idx_bits(NUM_COLS),
  parameter int LB        = idx_bits(WORD_W / CPU_W)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [BB-1:0]     wr_bank,
  input  logic [CB-1:0]     wr_col,
  input  logic [LB-1:0]     wr_lane,
  input  logic [CPU_W-1:0]  wr_data,
  input  logic [BB-1:0]     cpu_bank,
  input  logic [CB-1:0]     cpu_col,
  input  logic [LB-1:0]     cpu_lane,
  output logic [CPU_W-1:0]  cpu_word,
  input  logic [BB-1:0]     rd_bank,
  input  logic [CB-1:0]     rd_col,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = NUM_BANKS * NUM_COLS;

  logic [WORD_W-1:0] mem [DEPTH];

  function automatic int row_of(input logic [BB-1:0] b, input logic [CB-1:0] c);
    return int'(b) * NUM_COLS + int'(c);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[row_of(wr_bank, wr_col)][int'(wr_lane)*CPU_W +: CPU_W] <= wr_data;
  end

  logic [WORD_W-1:0] cpu_row;
  assign cpu_row  = mem[row_of(cpu_bank, cpu_col)];
  assign cpu_word = cpu_row[int'(cpu_lane)*CPU_W +: CPU_W];
  assign rd_word  = mem[row_of(rd_bank, rd_col)];

endmodule

// File: rtl/cbk_merge.sv
module cbk_merge import cbk_pkg::*; #(
  parameter int NUM_ARRAYS = 4,
  parameter int SLICE_W    = 64,
  parameter int COL_W      = 48
) (
  input  logic [NUM_ARRAYS*SLICE_W-1:0] word,
  output logic [NUM_ARRAYS*COL_W-1:0]   cfg
);
  logic [63:0] base;
  assign base = 64'(word[SLICE_W-1:0]);

  for (genvar a = 0; a < NUM_ARRAYS; a++) begin : g_arr
    logic [63:0] mask;
    logic [63:0] full;
    assign mask = 64'(word[a*SLICE_W +: SLICE_W]);
    assign full = apply_mask(base, mask, a != 0);
    assign cfg[a*COL_W +: COL_W] = full[COL_W-1:0];
  end

endmodule

// File: rtl/cbk_seq.sv
module cbk_seq import cbk_pkg::*; #(
  parameter int NUM_BANKS = 2,
  parameter int NUM_COLS  = 8,
  parameter int CFG_W     = 192,
  parameter int BB        = idx_bits(NUM_BANKS),
  parameter int CB        = idx_bits(NUM_COLS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] valid_set,
  output logic [NUM_BANKS-1:0] valid_bits,
  output logic [BB-1:0]        rd_bank,
  output logic [CB-1:0]        rd_col,
  input  logic [CFG_W-1:0]     cfg_in,
  output logic                 col_we,
  output logic [CB-1:0]        col_idx,
  output logic [CFG_W-1:0]     col_cfg,
  output logic                 eval_start,
  input  logic                 fit_done,
  output logic                 irq,
  input  logic                 irq_ack,
  output logic [BB-1:0]        irq_bank
);
  localparam logic [CB-1:0] LAST_COL  = CB'(NUM_COLS - 1);
  localparam logic [BB-1:0] LAST_BANK = BB'(NUM_BANKS - 1);

  seq_state_t          st;
  logic [BB-1:0]       cur, evb;
  logic [CB-1:0]       col;
  logic [NUM_BANKS-1:0] valid_q, clr_mask;

  // named internal events
  logic due_ready, last_col, bank_done, raise_evt;
  assign due_ready = valid_q[cur];
  assign last_col  = (col == LAST_COL);
  assign bank_done = (st == ST_START);
  assign raise_evt = !irq && ((st == ST_EVAL && fit_done) || st == ST_HOLD);

  assign rd_bank    = cur;
  assign rd_col     = col;
  assign valid_bits = valid_q;

  always_comb begin
    clr_mask = '0;
    if (bank_done) clr_mask[cur] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= (valid_q & ~clr_mask) | valid_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cur        <= '0;
      evb        <= '0;
      col        <= '0;
      col_we     <= 1'b0;
      col_idx    <= '0;
      col_cfg    <= '0;
      eval_start <= 1'b0;
    end else begin
      col_we     <= 1'b0;
      eval_start <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (due_ready) begin
            st  <= ST_LOAD;
            col <= '0;
          end
        end
        ST_LOAD: begin
          col_we  <= 1'b1;
          col_idx <= col;
          col_cfg <= cfg_in;
          if (last_col) st  <= ST_START;
          else          col <= col + 1'b1;
        end
        ST_START: begin
          eval_start <= 1'b1;
          evb        <= cur;
          cur        <= (cur == LAST_BANK) ? '0 : cur + 1'b1;
          st         <= ST_EVAL;
        end
        ST_EVAL: begin
          if (fit_done) st <= irq ? ST_HOLD : ST_IDLE;
        end
        ST_HOLD: begin
          if (!irq) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      irq_bank <= '0;
    end else if (raise_evt) begin
      irq      <= 1'b1;
      irq_bank <= evb;
    end else if (irq_ack) begin
      irq      <= 1'b0;
    end
  end

endmodule

// File: rtl/cbk_top.sv
module cbk_top import cbk_pkg::*; #(
  parameter int NUM_BANKS  = 2,
  parameter int NUM_COLS   = 8,
  parameter int NUM_ARRAYS = 4,
  parameter int SLICE_W    = 64,
  parameter int COL_W      = 48,
  parameter int CPU_W      = 32,
  parameter int BB         = idx_bits(NUM_BANKS),
  parameter int CB         = idx_bits(NUM_COLS),
  parameter int LB         = idx_bits(NUM_ARRAYS * SLICE_W / CPU_W),
  parameter int AW         = 1 + BB + CB + LB
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cpu_we,
  input  logic                        cpu_re,
  input  logic [AW-1:0]               cpu_addr,
  input  logic [CPU_W-1:0]            cpu_wdata,
  output logic [CPU_W-1:0]            cpu_rdata,
  output logic                        col_we,
  output logic [CB-1:0]               col_idx,
  output logic [NUM_ARRAYS*COL_W-1:0] col_cfg,
  output logic                        eval_start,
  input  logic                        fit_done,
  output logic                        irq,
  input  logic                        irq_ack,
  output logic [BB-1:0]               irq_bank
);
  localparam int WORD_W = NUM_ARRAYS * SLICE_W;
  localparam int CFG_W  = NUM_ARRAYS * COL_W;

  logic                 is_reg;
  logic [LB-1:0]        a_lane;
  logic [CB-1:0]        a_col;
  logic [BB-1:0]        a_bank;
  logic [NUM_BANKS-1:0] valid_set, valid_bits;
  logic [CPU_W-1:0]     cpu_word;
  logic [BB-1:0]        rd_bank;
  logic [CB-1:0]        rd_col;
  logic [WORD_W-1:0]    rd_word;
  logic [CFG_W-1:0]     cfg_merged;

  assign is_reg    = cpu_addr[AW-1];
  assign a_lane    = cpu_addr[LB-1:0];
  assign a_col     = cpu_addr[LB +: CB];
  assign a_bank    = cpu_addr[LB+CB +: BB];
  assign valid_set = (cpu_we && is_reg) ? cpu_wdata[NUM_BANKS-1:0] : '0;

  cbk_store #(.NUM_BANKS(NUM_BANKS), .NUM_COLS(NUM_COLS), .WORD_W(WORD_W),
              .CPU_W(CPU_W), .BB(BB), .CB(CB), .LB(LB)) u_store (
    .clk      (clk),
    .wr_en    (cpu_we && !is_reg),
    .wr_bank  (a_bank),
    .wr_col   (a_col),
    .wr_lane  (a_lane),
    .wr_data  (cpu_wdata),
    .cpu_bank (a_bank),
    .cpu_col  (a_col),
    .cpu_lane (a_lane),
    .cpu_word (cpu_word),
    .rd_bank  (rd_bank),
    .rd_col   (rd_col),
    .rd_word  (rd_word)
  );

  cbk_merge #(.NUM_ARRAYS(NUM_ARRAYS), .SLICE_W(SLICE_W), .COL_W(COL_W)) u_merge (
    .word (rd_word),
    .cfg  (cfg_merged)
  );

  cbk_seq #(.NUM_BANKS(NUM_BANKS), .NUM_COLS(NUM_COLS), .CFG_W(CFG_W),
            .BB(BB), .CB(CB)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_set  (valid_set),
    .valid_bits (valid_bits),
    .rd_bank    (rd_bank),
    .rd_col     (rd_col),
    .cfg_in     (cfg_merged),
    .col_we     (col_we),
    .col_idx    (col_idx),
    .col_cfg    (col_cfg),
    .eval_start (eval_start),
    .fit_done   (fit_done),
    .irq        (irq),
    .irq_ack    (irq_ack),
    .irq_bank   (irq_bank)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cpu_rdata <= '0;
    else if (cpu_re) cpu_rdata <= is_reg ? CPU_W'(valid_bits) : cpu_word;
  end

endmodule

// File: rtl/cbk_chk.sv
module cbk_chk #(
  parameter int CB = 3,
  parameter int BB = 1,
  parameter int NUM_COLS = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          col_we,
  input logic [CB-1:0] col_idx,
  input logic          eval_start,
  input logic          irq,
  input logic          irq_ack,
  input logic [BB-1:0] irq_bank
);
  localparam logic [CB-1:0] LAST = CB'(NUM_COLS - 1);

  // R5
  first_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_we) |-> col_idx == '0);

  // R5
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_we && col_idx != LAST) |=> (col_we && col_idx == $past(col_idx) + 1'b1));

  // R7
  start_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_start |-> (!col_we && $past(col_we) && $past(col_idx) == LAST));

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> (irq && $stable(irq_bank)));

  // R10
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_ack) |=> !irq);

endmodule

bind cbk_top cbk_chk #(.CB(CB), .BB(BB), .NUM_COLS(NUM_COLS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .col_we     (col_we),
  .col_idx    (col_idx),
  .eval_start (eval_start),
  .irq        (irq),
  .irq_ack    (irq_ack),
  .irq_bank   (irq_bank)
);

// File: tb/sim_cbk_top.sv
module sim_cbk_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         cpu_we = 1'b0, cpu_re = 1'b0;
  logic [7:0]   cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic [31:0]  cpu_rdata;
  logic         col_we;
  logic [2:0]   col_idx;
  logic [191:0] col_cfg;
  logic         eval_start;
  logic         fit_done = 1'b0;
  logic         irq;
  logic         irq_ack = 1'b0;
  logic         irq_bank;

  cbk_top u0 (.*);

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural model state
  logic [255:0] m_mem [16];
  int           m_st = 0, m_col = 0, m_cur = 0, m_evb = 0;
  int           m_valid = 0;
  bit           m_we = 0, m_start = 0, m_irq = 0;
  int           m_idx = 0, m_irqb = 0;
  logic [191:0] m_cfg = '0;
  logic [31:0]  m_rd = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_col = 0; m_cur = 0; m_evb = 0; m_valid = 0;
      m_we = 0; m_start = 0; m_irq = 0; m_idx = 0; m_irqb = 0; m_cfg = '0; m_rd = '0;
    end else begin
      int nvalid, nst;
      bit nirq;
      // processor side
      if (cpu_re) m_rd = cpu_addr[7] ? 32'(m_valid) : m_mem[cpu_addr[6:3]][cpu_addr[2:0]*32 +: 32];
      nvalid = m_valid | (cpu_we && cpu_addr[7] ? int'(cpu_wdata[1:0]) : 0);
      m_we = 0; m_start = 0; nst = m_st; nirq = m_irq;
      case (m_st)
        0: if (m_valid[m_cur]) begin nst = 1; m_col = 0; end
        1: begin
          logic [255:0] w;
          w = m_mem[m_cur*8 + m_col];
          m_we = 1; m_idx = m_col;
          for (int a = 0; a < 4; a++)
            m_cfg[a*48 +: 48] = (a == 0) ? w[47:0] : (w[47:0] ^ w[a*64 +: 48]);
          if (m_col == 7) nst = 2; else m_col++;
        end
        2: begin
          m_start = 1; m_evb = m_cur;
          nvalid = nvalid & ~(1 << m_cur) | (cpu_we && cpu_addr[7] ? int'(cpu_wdata[1:0]) : 0);
          m_cur = (m_cur + 1) % 2; nst = 3;
        end
        3: if (fit_done) begin
             if (m_irq) nst = 4; else begin nst = 0; nirq = 1; m_irqb = m_evb; end
           end
        default: if (!m_irq) begin nst = 0; nirq = 1; m_irqb = m_evb; end
      endcase
      if (m_irq && irq_ack) nirq = 0;
      m_irq = nirq; m_st = nst; m_valid = nvalid;
      if (cpu_we && !cpu_addr[7]) m_mem[cpu_addr[6:3]][cpu_addr[2:0]*32 +: 32] = cpu_wdata;
    end
  end

  // per-cycle comparison and event counters
  int we_seen = 0, we_while_irq = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(col_we == m_we, "R5 col_we", 192'(col_we), 192'(m_we));
      chk(eval_start == m_start, "R7 eval_start", 192'(eval_start), 192'(m_start));
      chk(irq == m_irq, "R9 irq", 192'(irq), 192'(m_irq));
      chk(int'(irq_bank) == m_irqb, "R9 irq_bank", 192'(irq_bank), 192'(m_irqb));
      chk(cpu_rdata == m_rd, "R2 cpu_rdata", 192'(cpu_rdata), 192'(m_rd));
      if (m_we) begin
        chk(int'(col_idx) == m_idx, "R5 col_idx", 192'(col_idx), 192'(m_idx));
        chk(col_cfg == m_cfg, "R6 col_cfg", col_cfg, m_cfg);
      end
      if (col_we) we_seen++;
      if (col_we && irq) we_while_irq++;
    end
  end

  function automatic logic [31:0] pat(input int b, input int c, input int l, input int s);
    return 32'((s * 32'h9E3779B1) ^ (b << 24) ^ (c << 16) ^ (l * 32'h0101_0011) ^ (l << 5));
  endfunction

  task automatic cpu_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); cpu_re = 1'b1; cpu_addr = a;
    @(negedge clk); cpu_re = 1'b0; d = cpu_rdata;
  endtask

  task automatic fill(input int b, input int s);
    for (int c = 0; c < 8; c++)
      for (int l = 0; l < 8; l++)
        cpu_wr(8'((b << 6) | (c << 3) | l), pat(b, c, l, s));
  endtask

  task automatic pulse_fit();
    @(negedge clk); fit_done = 1'b1;
    @(negedge clk); fit_done = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic wait_start(input string req);
    int n = 0;
    while (!eval_start && n < 200) begin @(negedge clk); n++; end
    chk(eval_start, req, 192'(eval_start), 192'(1));
  endtask

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!col_we && !eval_start && !irq, "R1 outputs idle", 192'({col_we, eval_start, irq}), 192'(0));
    cpu_rd(8'h80, d);
    chk(d == 0, "R1 ready bits clear", 192'(d), 192'(0));

    fill(0, 1);
    fill(1, 2);
    cpu_rd(8'h2D, d); // bank0 col5 lane5
    chk(d == pat(0, 5, 5, 1), "R2 readback", 192'(d), 192'(pat(0, 5, 5, 1)));
    cpu_rd(8'h5A, d); // bank1 col3 lane2
    chk(d == pat(1, 3, 2, 2), "R2 readback bank1", 192'(d), 192'(pat(1, 3, 2, 2)));

    // R3 zero write has no effect, set only bank1
    cpu_wr(8'h80, 32'h0);
    cpu_rd(8'h80, d);
    chk(d == 0, "R3 zero write ignored", 192'(d), 192'(0));
    w0 = we_seen;
    cpu_wr(8'h80, 32'h2);
    cpu_rd(8'h80, d);
    chk(d == 2, "R3 set bank1", 192'(d), 192'(2));
    repeat (20) @(negedge clk);
    // R4 bank0 due but not ready: nothing loads; R8 no skipping to bank1
    chk(we_seen == w0 && !eval_start, "R4 R8 idle while due bank empty", 192'(we_seen - w0), 192'(0));

    cpu_wr(8'h80, 32'h1);
    wait_start("R7 start bank0");
    chk(we_seen - w0 == 8, "R5 eight columns", 192'(we_seen - w0), 192'(8));
    cpu_rd(8'h80, d);
    chk(d == 2, "R7 bank0 ready cleared", 192'(d), 192'(2));

    repeat (3) @(negedge clk);
    pulse_fit();
    chk(irq && irq_bank == 1'b0, "R9 irq for bank0", 192'({irq, irq_bank}), 192'(2));
    // bank1 loads while irq pending
    wait_start("R8 start bank1");
    chk(we_while_irq >= 8, "R11 load during pending irq", 192'(we_while_irq), 192'(8));
    repeat (2) @(negedge clk);
    pulse_fit();
    repeat (3) @(negedge clk);
    chk(irq && irq_bank == 1'b0, "R10 second result held back", 192'({irq, irq_bank}), 192'(2));
    pulse_ack();
    chk(!irq, "R10 irq drops after ack", 192'(irq), 192'(0));
    @(negedge clk);
    chk(irq && irq_bank == 1'b1, "R10 deferred irq bank1", 192'({irq, irq_bank}), 192'(3));
    pulse_ack();

    // R8 rotation returns to bank0 with new contents
    cpu_rd(8'h80, d);
    chk(d == 0, "R7 all banks consumed", 192'(d), 192'(0));
    fill(0, 7);
    cpu_wr(8'h80, 32'h1);
    wait_start("R8 start bank0 again");
    repeat (2) @(negedge clk);
    pulse_fit();
    chk(irq && irq_bank == 1'b0, "R8 rotation back to bank0", 192'({irq, irq_bank}), 192'(2));
    pulse_ack();
    repeat (4) @(negedge clk);
    chk(!irq && !col_we, "R4 idle after rotation", 192'({irq, col_we}), 192'(0));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule